// File: doc/BRIEF.md
# Channel-Loop Interrupt Aggregator

This block gathers loop-point events from 64 sample-playback channels and three global event sources (an interval timer and the two directions of a serial music port). It reduces all of them to a single level interrupt line. Each channel event arrives as a one-cycle pulse and sets a sticky per-channel pending bit. Each global event likewise sets a sticky pending bit. A host reaches six 32-bit word locations through a plain synchronous strobe port. Two of them are enable masks for the channels, one holds the global enables, two expose the raw per-channel pending state, and one is the global pending word.

The global pending word does more than hold flags. Its channel summary bit is set when any enabled channel is pending. Its low six bits then give the number of the highest such channel. A host can service channels by reading that word and writing the same value back. Writing it back with the summary bit set clears exactly the named channel and leaves every other channel's state alone. A force bit in the global enable word holds the interrupt asserted regardless of pending state. The interrupt output is registered.

Top module: `loop_irq_hub`

## Requirements
- R1: After reset all six readable words read 0 and irqOut is 0.
- R2: A pulse on loopEvt[c] sets pending bit c whether or not channel c is enabled. Channels 0 to 31 appear at word address 4, bit c. Channels 32 to 63 appear at word address 5, bit c-32.
- R3: Bit 6 of the global pending word (address 0) is 1 exactly when some channel is both pending and enabled. Bits 5:0 then hold the highest such channel number, and they read 0 while bit 6 is 0.
- R4: A write to address 0 with bit 6 set clears the pending bit of the channel numbered by bits 5:0 of the written value and no other channel. A write to address 0 with bit 6 clear changes no channel state.
- R5: Pulses on timerEvt, midiTxEvt and midiRxEvt set bits 9, 8 and 7 of the global pending word. Writing 1 to one of those bits clears it, and writing 0 leaves it unchanged.
- R6: Bits 2, 1 and 0 of the global enable word (address 1) enable the timer, transmit and receive sources. irqOut is 1 one cycle after the state holds an enabled pending global source or a set channel summary, and 0 one cycle after the state holds neither (with force clear).
- R7: Bit 20 of the global enable word forces irqOut to 1 from the cycle after it is written, independent of pending state.
- R8: An event that arrives in the same cycle as a write that would clear its pending bit leaves that bit set. This applies to global sources and to channels.
- R9: The channel enable words (address 2 for channels 0 to 31, address 3 for channels 32 to 63) read back what was written. The channel pending words (addresses 4 and 5) clear the bits written as 1.
- R10: Addresses 6 and 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Write strobe for one cycle |
| regAddr | input | 3 | Word address for read and write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data of the addressed word (combinational) |
| loopEvt | input | 64 | One-cycle loop event pulse per channel |
| timerEvt | input | 1 | Interval-timer terminal count pulse |
| midiTxEvt | input | 1 | Serial music port transmit-empty pulse |
| midiRxEvt | input | 1 | Serial music port receive pulse |
| irqOut | output | 1 | Registered level interrupt |

## Verification
The assertions assume that event inputs are single-cycle pulses and that they and the write strobe change only between clock edges. They also assume that no write and event combination stays active for more than the cycle it targets. The stimulus drives every input on the falling edge and holds each pulse for exactly one cycle. Collisions between an event and a clearing write are created deliberately, within one cycle, so the properties on event persistence are exercised under the same single-cycle pulse assumption.

// File: rtl/loop_irq_pkg.sv
package loop_irq_pkg;

  localparam int GP_TIMER_BIT = 9;
  localparam int GP_TX_BIT    = 8;
  localparam int GP_RX_BIT    = 7;
  localparam int GP_SUM_BIT   = 6;
  localparam int GE_FORCE_BIT = 20;
  localparam int GE_TIMER_BIT = 2;
  localparam int GE_TX_BIT    = 1;
  localparam int GE_RX_BIT    = 0;
  localparam int NUM_GLOB     = 3;

  typedef enum logic [2:0] {
    SEL_GPEND  = 3'd0,
    SEL_GEN    = 3'd1,
    SEL_CENLO  = 3'd2,
    SEL_CENHI  = 3'd3,
    SEL_CPLO   = 3'd4,
    SEL_CPHI   = 3'd5,
    SEL_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrGlobPend;
    logic wrGlobEn;
    logic wrChanEnLo;
    logic wrChanEnHi;
    logic wrChanPendLo;
    logic wrChanPendHi;
    logic chanClr;
  } wrStrobe_t;

endpackage

// File: rtl/loop_irq_ctrl.sv
module loop_irq_ctrl
  import loop_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              sumBitIn,
  output wrStrobe_t         strobe,
  output regSel_e           rdSel
);

  always_comb begin
    case (regAddr)
      ADDR_W'(0): rdSel = SEL_GPEND;
      ADDR_W'(1): rdSel = SEL_GEN;
      ADDR_W'(2): rdSel = SEL_CENLO;
      ADDR_W'(3): rdSel = SEL_CENHI;
      ADDR_W'(4): rdSel = SEL_CPLO;
      ADDR_W'(5): rdSel = SEL_CPHI;
      default:    rdSel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobe = '0;
    if (regWe) begin
      strobe.wrGlobPend   = (rdSel == SEL_GPEND);
      strobe.wrGlobEn     = (rdSel == SEL_GEN);
      strobe.wrChanEnLo   = (rdSel == SEL_CENLO);
      strobe.wrChanEnHi   = (rdSel == SEL_CENHI);
      strobe.wrChanPendLo = (rdSel == SEL_CPLO);
      strobe.wrChanPendHi = (rdSel == SEL_CPHI);
      strobe.chanClr      = (rdSel == SEL_GPEND) && sumBitIn;
    end
  end

endmodule

// File: rtl/loop_irq_dp.sv
module loop_irq_dp
  import loop_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  wrStrobe_t             strobe,
  input  regSel_e               rdSel,
  input  logic [REG_W-1:0]      regWdata,
  input  logic [2*REG_W-1:0]    loopEvt,
  input  logic                  timerEvt,
  input  logic                  midiTxEvt,
  input  logic                  midiRxEvt,
  output logic [REG_W-1:0]      regRdata,
  output logic [REG_W-1:0]      gpWord,
  output logic [REG_W-1:0]      geWord,
  output logic [2*REG_W-1:0]    chanPendVec,
  output logic [2*REG_W-1:0]    chanEnVec,
  output logic                  irqOut
);

  localparam int NUM_CHAN = 2 * REG_W;
  localparam int IDX_W    = $clog2(NUM_CHAN);

  logic [NUM_CHAN-1:0] chanPend, chanPendNext;
  logic [NUM_CHAN-1:0] chanEn;
  logic [NUM_CHAN-1:0] effVec;
  logic [NUM_GLOB-1:0] globPend, globPendNext, globEvt, globClr;
  logic [NUM_GLOB-1:0] globEn;
  logic                forceEn;
  logic [IDX_W-1:0]    topIdx;
  logic                anyEff;
  logic [IDX_W-1:0]    clrIdx;

  assign globEvt = {timerEvt, midiTxEvt, midiRxEvt};
  assign clrIdx  = regWdata[IDX_W-1:0];

  // global source pending: write-1-to-clear, event wins
  always_comb begin
    globClr = strobe.wrGlobPend ?
              {regWdata[GP_TIMER_BIT], regWdata[GP_TX_BIT], regWdata[GP_RX_BIT]} : '0;
    globPendNext = (globPend & ~globClr) | globEvt;
  end

  // per-channel pending: word W1C, indexed clear, event wins
  always_comb begin
    chanPendNext = chanPend;
    if (strobe.wrChanPendLo) chanPendNext[REG_W-1:0] = chanPendNext[REG_W-1:0] & ~regWdata;
    if (strobe.wrChanPendHi) chanPendNext[NUM_CHAN-1:REG_W] = chanPendNext[NUM_CHAN-1:REG_W] & ~regWdata;
    if (strobe.chanClr) chanPendNext[clrIdx] = 1'b0;
    chanPendNext = chanPendNext | loopEvt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chanPend <= '0;
      chanEn   <= '0;
      globPend <= '0;
      globEn   <= '0;
      forceEn  <= 1'b0;
    end else begin
      chanPend <= chanPendNext;
      globPend <= globPendNext;
      if (strobe.wrChanEnLo) chanEn[REG_W-1:0]        <= regWdata;
      if (strobe.wrChanEnHi) chanEn[NUM_CHAN-1:REG_W] <= regWdata;
      if (strobe.wrGlobEn) begin
        globEn  <= {regWdata[GE_TIMER_BIT], regWdata[GE_TX_BIT], regWdata[GE_RX_BIT]};
        forceEn <= regWdata[GE_FORCE_BIT];
      end
    end
  end

  // highest enabled pending channel
  assign effVec = chanPend & chanEn;
  assign anyEff = |effVec;

  always_comb begin
    topIdx = '0;
    for (int i = 0; i < NUM_CHAN; i++) begin
      if (effVec[i]) topIdx = IDX_W'(i);
    end
  end

  always_comb begin
    gpWord = '0;
    gpWord[GP_TIMER_BIT] = globPend[2];
    gpWord[GP_TX_BIT]    = globPend[1];
    gpWord[GP_RX_BIT]    = globPend[0];
    gpWord[GP_SUM_BIT]   = anyEff;
    if (anyEff) gpWord[IDX_W-1:0] = topIdx;
  end

  always_comb begin
    geWord = '0;
    geWord[GE_FORCE_BIT] = forceEn;
    geWord[GE_TIMER_BIT] = globEn[2];
    geWord[GE_TX_BIT]    = globEn[1];
    geWord[GE_RX_BIT]    = globEn[0];
  end

  always_comb begin
    case (rdSel)
      SEL_GPEND: regRdata = gpWord;
      SEL_GEN:   regRdata = geWord;
      SEL_CENLO: regRdata = chanEn[REG_W-1:0];
      SEL_CENHI: regRdata = chanEn[NUM_CHAN-1:REG_W];
      SEL_CPLO:  regRdata = chanPend[REG_W-1:0];
      SEL_CPHI:  regRdata = chanPend[NUM_CHAN-1:REG_W];
      default:   regRdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irqOut <= 1'b0;
    else        irqOut <= forceEn | anyEff | (|(globPend & globEn));
  end

  assign chanPendVec = chanPend;
  assign chanEnVec   = chanEn;

endmodule

// File: rtl/loop_irq_hub.sv
module loop_irq_hub
  import loop_irq_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic [2*REG_W-1:0] loopEvt,
  input  logic               timerEvt,
  input  logic               midiTxEvt,
  input  logic               midiRxEvt,
  output logic               irqOut
);

  wrStrobe_t          strobe;
  regSel_e            rdSel;
  logic [REG_W-1:0]   gpWord;
  logic [REG_W-1:0]   geWord;
  logic [2*REG_W-1:0] chanPendVec;
  logic [2*REG_W-1:0] chanEnVec;

  loop_irq_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .sumBitIn (regWdata[GP_SUM_BIT]),
    .strobe   (strobe),
    .rdSel    (rdSel)
  );

  loop_irq_dp #(.REG_W(REG_W)) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .rdSel       (rdSel),
    .regWdata    (regWdata),
    .loopEvt     (loopEvt),
    .timerEvt    (timerEvt),
    .midiTxEvt   (midiTxEvt),
    .midiRxEvt   (midiRxEvt),
    .regRdata    (regRdata),
    .gpWord      (gpWord),
    .geWord      (geWord),
    .chanPendVec (chanPendVec),
    .chanEnVec   (chanEnVec),
    .irqOut      (irqOut)
  );

endmodule

// File: rtl/loop_irq_hub_chk.sv
module loop_irq_hub_chk #(
  parameter int REG_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*REG_W-1:0] loopEvt,
  input logic               timerEvt,
  input logic               irqOut,
  input logic [REG_W-1:0]   gpWord,
  input logic [REG_W-1:0]   geWord,
  input logic [2*REG_W-1:0] chanPendVec,
  input logic [2*REG_W-1:0] chanEnVec
);

  localparam int IDX_W = $clog2(2 * REG_W);

  logic [2*REG_W-1:0] effV;
  logic [IDX_W-1:0]   idxV;
  assign effV = chanPendVec & chanEnVec;
  assign idxV = gpWord[IDX_W-1:0];

  // R3
  sum_idx_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpWord[6] |-> effV[idxV]);

  // R3
  sum_idx_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpWord[6] |-> ((effV >> idxV) == {{(2*REG_W-1){1'b0}}, 1'b1}));

  // R3
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gpWord[6] |-> (idxV == '0));

  // R2
  loop_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|loopEvt) |=> ((chanPendVec & $past(loopEvt)) == $past(loopEvt)));

  // R8
  timer_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timerEvt |=> gpWord[9]);

  // R7
  force_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    geWord[20] |=> irqOut);

  // R6
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!geWord[20] && !gpWord[6] && ((gpWord[9:7] & geWord[2:0]) == 3'b000)) |=> !irqOut);

endmodule

bind loop_irq_hub loop_irq_hub_chk #(.REG_W(REG_W)) chk_i (.*);

// File: tb/loop_irq_hub_tb_top.sv
module loop_irq_hub_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [63:0] loopEvt = '0;
  logic        timerEvt = 1'b0;
  logic        midiTxEvt = 1'b0;
  logic        midiRxEvt = 1'b0;
  logic        irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  loop_irq_hub dut_i (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .loopEvt(loopEvt),
    .timerEvt(timerEvt), .midiTxEvt(midiTxEvt), .midiRxEvt(midiRxEvt),
    .irqOut(irqOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic pulseChan(input logic [63:0] v);
    @(negedge clk);
    loopEvt = v;
    @(negedge clk);
    loopEvt = '0;
  endtask

  task automatic checkIrq(input string tag, input logic exp);
    @(negedge clk);
    check(tag, {31'b0, irqOut}, {31'b0, exp});
  endtask

  task automatic checkChan(input string tag, input logic [63:0] expPend);
    logic [31:0] v;
    rd(3'd4, v); check(tag, v, expPend[31:0]);
    rd(3'd5, v); check(tag, v, expPend[63:32]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [63:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], v); check("R1 reset word", v, 32'h0);
    end
    check("R1 reset irq", {31'b0, irqOut}, 32'h0);

    // R9 channel enables read back
    wr(3'd2, 32'hA5A5_0F0F); rd(3'd2, v); check("R9 enable lo", v, 32'hA5A5_0F0F);
    wr(3'd3, 32'h1234_8001); rd(3'd3, v); check("R9 enable hi", v, 32'h1234_8001);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);

    // R2 R3 R4 sweep every channel, enabled
    for (int c = 0; c < 64; c++) begin
      m = 64'd1 << c;
      pulseChan(m);
      checkChan("R2 pending bit", m);
      rd(3'd0, v); check("R3 summary index", v, 32'h40 | c);
      checkIrq("R6 irq from channel", 1'b1);
      wr(3'd0, 32'h40 | c);
      checkChan("R4 indexed clear", 64'h0);
      rd(3'd0, v); check("R3 summary idle", v, 32'h0);
      checkIrq("R6 irq idle", 1'b0);
    end

    // R3 highest first, R4 clears one at a time
    pulseChan((64'd1 << 3) | (64'd1 << 17) | (64'd1 << 40) | (64'd1 << 63));
    rd(3'd0, v); check("R3 top 63", v, 32'h40 | 63);
    wr(3'd0, 32'h40 | 63); rd(3'd0, v); check("R3 top 40", v, 32'h40 | 40);
    checkChan("R4 only 63 cleared", (64'd1 << 3) | (64'd1 << 17) | (64'd1 << 40));
    wr(3'd0, 32'h40 | 40); rd(3'd0, v); check("R3 top 17", v, 32'h40 | 17);
    // R4 index of non-pending channel clears nothing else
    wr(3'd0, 32'h40 | 5); rd(3'd0, v); check("R4 miss index", v, 32'h40 | 17);
    // R4 bit6 clear: no channel change
    wr(3'd0, 32'h0000_0011); rd(3'd0, v); check("R4 no bit6", v, 32'h40 | 17);
    wr(3'd0, 32'h40 | 17); rd(3'd0, v); check("R3 top 3", v, 32'h40 | 3);
    wr(3'd0, 32'h40 | 3); rd(3'd0, v); check("R3 none", v, 32'h0);

    // R2 disabled channels still latch, R3 ignores them
    wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    pulseChan(64'd1 << 10);
    checkChan("R2 latched while disabled", 64'd1 << 10);
    rd(3'd0, v); check("R3 disabled no summary", v, 32'h0);
    checkIrq("R6 disabled no irq", 1'b0);
    wr(3'd2, 32'h0000_0400);
    rd(3'd0, v); check("R3 enabled later", v, 32'h40 | 10);
    pulseChan(64'd1 << 50);
    rd(3'd0, v); check("R3 higher disabled ignored", v, 32'h40 | 10);
    // R9 word W1C on pending regs
    wr(3'd5, 32'h0004_0000); checkChan("R9 pend hi w1c", 64'd1 << 10);
    wr(3'd4, 32'h0000_0400); checkChan("R9 pend lo w1c", 64'h0);
    wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);

    // R5 R6 global sources, each with enable off then on
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      timerEvt = (s == 0); midiTxEvt = (s == 1); midiRxEvt = (s == 2);
      @(negedge clk);
      timerEvt = 1'b0; midiTxEvt = 1'b0; midiRxEvt = 1'b0;
      rd(3'd0, v); check("R5 source sets", v, 32'h200 >> s);
      checkIrq("R6 source disabled", 1'b0);
      wr(3'd1, 32'h4 >> s);
      checkIrq("R6 source enabled", 1'b1);
      wr(3'd0, 32'h0);
      rd(3'd0, v); check("R5 write zero keeps", v, 32'h200 >> s);
      wr(3'd0, 32'h200 >> s);
      rd(3'd0, v); check("R5 w1c clears", v, 32'h0);
      checkIrq("R6 cleared", 1'b0);
      wr(3'd1, 32'h0);
    end

    // R8 collisions
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd0; regWdata = 32'h200; timerEvt = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; timerEvt = 1'b0;
    rd(3'd0, v); check("R8 timer event wins", v, 32'h200);
    wr(3'd0, 32'h200);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd0; regWdata = 32'h40 | 21; loopEvt = 64'd1 << 21;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; loopEvt = '0;
    checkChan("R8 channel event wins index", 64'd1 << 21);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'd4; regWdata = 32'h0020_0000; loopEvt = 64'd1 << 21;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0; loopEvt = '0;
    checkChan("R8 channel event wins word", 64'd1 << 21);
    wr(3'd0, 32'h40 | 21);

    // R7 force
    wr(3'd1, 32'h0010_0000);
    rd(3'd1, v); check("R7 force readback", v, 32'h0010_0000);
    checkIrq("R7 forced irq", 1'b1);
    wr(3'd1, 32'h0);
    checkIrq("R7 released", 1'b0);

    // R10 unused addresses
    rd(3'd6, v); check("R10 addr6 reads 0", v, 32'h0);
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, v); check("R10 addr7 reads 0", v, 32'h0);
    rd(3'd1, v); check("R10 enable untouched", v, 32'h0);
    rd(3'd2, v); check("R10 chan en untouched", v, 32'hFFFF_FFFF);
    checkChan("R10 pending untouched", 64'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule